// File: doc/BRIEF.md
# Slope-Directed Track Multiplicity Scanner

This block runs after the common slope of a set of parallel straight tracks has been found. It walks a start offset across the whole column range of a multi-plane hit image and, at every offset, forms one straight line of addresses with the given slope. The line sum is the number of planes whose pixel on that line is fired. The sums make a one-dimensional profile. Peaks in this profile are the tracks, and the number of peaks is the event multiplicity.

Each plane memory is read through its own address bus, and one data bit per plane returns on the next clock. A start pulse latches the slope and the threshold and begins a scan. For each track the block pushes an (offset, points) pair into a 16-entry result queue, which the host drains with a pop strobe. When the scan ends, `done` rises and the track total and the overflow flag are final.

Top module: `track_scan`

## Requirements
- R1: After reset, `busy`, `done`, `fifoValid` and `overflow` are 0 and `trackCount` is 0.
- R2: The scan uses offsets o = 0 to MCOLS-1 in ascending order. Plane p is addressed at o + p*slope on bits [p*AW +: AW] of `memAddr`, and `memBit[p]` returns that pixel one clock later. An address below 0 or at or above MCOLS counts as an unfired pixel, whatever bit the memory returns.
- R3: The points of an offset are the number of planes whose pixel on that offset's line is fired.
- R4: An offset is a track when its points are at least `threshold`, strictly greater than the points of the previous offset, and not less than the points of the next offset. The points before offset 0 and after offset MCOLS-1 count as 0.
- R5: A run of equal peak sums (a plateau) gives one track, at its lowest offset.
- R6: Each track pushes one entry into the result queue, in ascending offset order. The head entry appears on `fifoOff` and `fifoPts` while `fifoValid` is 1, and a `fifoPop` pulse removes it.
- R7: `trackCount` counts every track of the scan, including tracks that do not fit. The queue holds 16 entries. `overflow` becomes 1 when a track is found while the queue is full and no pop is made in that cycle, and that track's entry is dropped. A new scan clears both `trackCount` and `overflow`.
- R8: A push and a pop in the same cycle on a full queue both take effect: the new entry is kept and `overflow` stays 0.
- R9: `done` rises exactly MCOLS+2 clocks after the clock edge that accepts `start`. It stays high until the next accepted start. `busy` is high during the scan. A new start does not empty the queue.
- R10: A `start` pulse while `busy` is high is ignored. The scan in progress keeps its timing and its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a scan; accepted when not busy |
| slope | input | AW+1 | Signed address step per plane, latched at start |
| threshold | input | CW | Minimum points for a track, latched at start |
| memAddr | output | NPLANES*AW | Per-plane read addresses, plane p at [p*AW +: AW] |
| memBit | input | NPLANES | Per-plane pixel bits, one clock after the address |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished; results final |
| trackCount | output | TCW | Tracks found in the last scan |
| overflow | output | 1 | A track was dropped because the queue was full |
| fifoValid | output | 1 | Result queue not empty |
| fifoOff | output | AW | Offset of the head entry |
| fifoPts | output | CW | Points of the head entry |
| fifoPop | input | 1 | Remove the head entry |

## Verification
Two functions can land in the same cycle: a track push into the result queue and a host pop from it, while the queue is full. The bench fills the queue with a scan that finds more tracks than fit, so overflow is also exercised. It then starts a second scan with a track at offset 0. Its pop monitor is timed so that the first pop happens at the clock edge that pushes this track. The pass condition is that `overflow` stays 0 and every entry, both the sixteen old ones and the new ones, comes out in order with the expected offsets and points.

// File: rtl/track_scan_pkg.sv
package track_scan_pkg;
  typedef struct packed {
    logic clear;
    logic issue;
    logic flush;
  } scanCtl_t;

  typedef enum logic [2:0] {ST_IDLE, ST_SCAN, ST_DRAIN, ST_FLUSH, ST_DONE} scanState_t;
endpackage

// File: rtl/track_scan_ctrl.sv
module track_scan_ctrl
  import track_scan_pkg::*;
#(
  parameter int MCOLS = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output scanCtl_t      ctl,
  output logic [AW-1:0] offset,
  output logic          busy,
  output logic          done
);
  localparam logic [AW-1:0] LAST_OFF = AW'(MCOLS - 1);

  scanState_t state;
  logic accept;

  assign accept = start && (state == ST_IDLE || state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      offset <= '0;
    end else if (accept) begin
      state  <= ST_SCAN;
      offset <= '0;
    end else begin
      case (state)
        ST_SCAN: begin
          offset <= offset + 1'b1;
          if (offset == LAST_OFF) state <= ST_DRAIN;
        end
        ST_DRAIN: state <= ST_FLUSH;
        ST_FLUSH: state <= ST_DONE;
        default:  ;
      endcase
    end
  end

  always_comb begin
    ctl.clear = accept;
    ctl.issue = (state == ST_SCAN);
    ctl.flush = (state == ST_FLUSH);
  end

  assign busy = (state == ST_SCAN) || (state == ST_DRAIN) || (state == ST_FLUSH);
  assign done = (state == ST_DONE);

  // R10: a start pulse in mid-scan must not disturb the offset walk
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN && offset != LAST_OFF) |=> (state == ST_SCAN && offset == $past(offset) + 1'b1));

  // R9: done is held until a new start arrives
  p_done_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);
endmodule

// File: rtl/track_scan_dp.sv
module track_scan_dp
  import track_scan_pkg::*;
#(
  parameter int NPLANES = 8,
  parameter int MCOLS   = 64,
  parameter int AW      = 6,
  parameter int CW      = 4,
  parameter int TCW     = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  scanCtl_t              ctl,
  input  logic [AW-1:0]         offset,
  input  logic signed [AW:0]    slope,
  input  logic [CW-1:0]         threshold,
  output logic [NPLANES*AW-1:0] memAddr,
  input  logic [NPLANES-1:0]    memBit,
  input  logic                  fifoFull,
  input  logic                  fifoPop,
  output logic                  pushValid,
  output logic [AW-1:0]         pushOff,
  output logic [CW-1:0]         pushPts,
  output logic [TCW-1:0]        trackCount,
  output logic                  overflow
);
  localparam int EW = AW + $clog2(NPLANES) + 2;

  logic signed [AW:0] slopeQ;
  logic [CW-1:0]      thrQ;
  logic [NPLANES-1:0] inRange, maskQ;
  logic               issueQ;
  logic [AW-1:0]      offQ;
  logic [CW-1:0]      sampleCnt, nextCnt, prevCnt, curCnt;
  logic [AW-1:0]      curOff;
  logic               curValid, evalNow, isPeak;

  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    logic [EW-1:0] fullAddr;
    assign fullAddr = EW'(offset) + EW'(p) * EW'(slopeQ);
    assign inRange[p] = !fullAddr[EW-1] && (fullAddr[EW-2:0] < (EW-1)'(MCOLS));
    assign memAddr[p*AW +: AW] = fullAddr[AW-1:0];
  end

  always_comb begin
    sampleCnt = '0;
    for (int p = 0; p < NPLANES; p++) sampleCnt = sampleCnt + CW'(memBit[p] & maskQ[p]);
  end

  assign nextCnt = ctl.flush ? '0 : sampleCnt;
  assign evalNow = curValid && (issueQ || ctl.flush);
  assign isPeak  = evalNow && (curCnt >= thrQ) && (curCnt > prevCnt) && (curCnt >= nextCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slopeQ <= '0; thrQ <= '0; maskQ <= '0; issueQ <= 1'b0; offQ <= '0;
      prevCnt <= '0; curCnt <= '0; curOff <= '0; curValid <= 1'b0;
      trackCount <= '0; overflow <= 1'b0;
    end else begin
      maskQ  <= inRange;
      issueQ <= ctl.issue;
      offQ   <= offset;
      if (ctl.clear) begin
        slopeQ     <= slope;
        thrQ       <= threshold;
        curValid   <= 1'b0;
        prevCnt    <= '0;
        trackCount <= '0;
        overflow   <= 1'b0;
      end else begin
        if (issueQ) begin
          prevCnt  <= curValid ? curCnt : '0;
          curCnt   <= sampleCnt;
          curOff   <= offQ;
          curValid <= 1'b1;
        end else if (ctl.flush) begin
          curValid <= 1'b0;
        end
        if (isPeak) begin
          trackCount <= trackCount + 1'b1;
          if (fifoFull && !fifoPop) overflow <= 1'b1;
        end
      end
    end
  end

  assign pushValid = isPeak;
  assign pushOff   = curOff;
  assign pushPts   = curCnt;

  // R4: a track needs a strict rise, so two neighbouring offsets are never both tracks
  p_no_adjacent_peaks_r4: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |=> !pushValid);

  // R7: overflow rises only after a track meets a full queue with no pop
  p_overflow_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(pushValid && fifoFull && !fifoPop));

  // R7: every track bumps the count
  p_track_counted_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !ctl.clear) |=> (trackCount == $past(trackCount) + 1'b1));
endmodule

// File: rtl/track_scan_fifo.sv
module track_scan_fifo #(
  parameter int DEPTH = 16,
  parameter int AW    = 6,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic [AW-1:0] pushOff,
  input  logic [CW-1:0] pushPts,
  input  logic          pop,
  output logic          full,
  output logic          valid,
  output logic [AW-1:0] headOff,
  output logic [CW-1:0] headPts
);
  localparam int PW = $clog2(DEPTH);
  localparam int NW = $clog2(DEPTH + 1);

  logic [AW-1:0] memOff [DEPTH];
  logic [CW-1:0] memPts [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr;
  logic [NW-1:0] fill;
  logic          doPush, doPop;

  assign full   = (fill == NW'(DEPTH));
  assign valid  = (fill != '0);
  assign doPop  = pop && valid;
  assign doPush = push && (!full || doPop);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] ptr);
    return (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) begin
      memOff[wrPtr] <= pushOff;
      memPts[wrPtr] <= pushPts;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0; wrPtr <= '0; fill <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      case ({doPush, doPop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: ;
      endcase
    end
  end

  assign headOff = memOff[rdPtr];
  assign headPts = memPts[rdPtr];

  // R8: push and pop on a full queue leave it full
  p_full_swap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && pop) |=> full);

  // R7: a push into a full queue without a pop is dropped
  p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> (full && $stable(wrPtr)));
endmodule

// File: rtl/track_scan.sv
module track_scan
  import track_scan_pkg::*;
#(
  parameter int NPLANES = 8,
  parameter int MCOLS   = 64,
  parameter int DEPTH   = 16,
  parameter int AW      = $clog2(MCOLS),
  parameter int CW      = $clog2(NPLANES + 1),
  parameter int TCW     = $clog2(MCOLS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic signed [AW:0]    slope,
  input  logic [CW-1:0]         threshold,
  output logic [NPLANES*AW-1:0] memAddr,
  input  logic [NPLANES-1:0]    memBit,
  output logic                  busy,
  output logic                  done,
  output logic [TCW-1:0]        trackCount,
  output logic                  overflow,
  output logic                  fifoValid,
  output logic [AW-1:0]         fifoOff,
  output logic [CW-1:0]         fifoPts,
  input  logic                  fifoPop
);
  scanCtl_t      ctl;
  logic [AW-1:0] offset;
  logic          fifoFull, pushValid;
  logic [AW-1:0] pushOff;
  logic [CW-1:0] pushPts;

  track_scan_ctrl #(.MCOLS(MCOLS), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .ctl(ctl), .offset(offset),
    .busy(busy), .done(done)
  );

  track_scan_dp #(.NPLANES(NPLANES), .MCOLS(MCOLS), .AW(AW), .CW(CW), .TCW(TCW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .offset(offset), .slope(slope),
    .threshold(threshold), .memAddr(memAddr), .memBit(memBit),
    .fifoFull(fifoFull), .fifoPop(fifoPop), .pushValid(pushValid),
    .pushOff(pushOff), .pushPts(pushPts), .trackCount(trackCount), .overflow(overflow)
  );

  track_scan_fifo #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_fifo (
    .clk(clk), .rstN(rstN), .push(pushValid), .pushOff(pushOff), .pushPts(pushPts),
    .pop(fifoPop), .full(fifoFull), .valid(fifoValid), .headOff(fifoOff), .headPts(fifoPts)
  );
endmodule

// File: tb/track_scan_bench.sv
`timescale 1ns/1ps
module track_scan_bench;
  localparam int NP = 8, M = 64, DEPTH = 16;
  localparam int AW = 6, CW = 4, TCW = 7;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                rstN, start, fifoPop, popEn;
  logic signed [AW:0]  slope;
  logic [CW-1:0]       threshold;
  logic [NP*AW-1:0]    memAddr;
  logic [NP-1:0]       memBit;
  logic                busy, done, overflow, fifoValid;
  logic [TCW-1:0]      trackCount;
  logic [AW-1:0]       fifoOff;
  logic [CW-1:0]       fifoPts;

  track_scan u_track_scan (
    .clk(clk), .rstN(rstN), .start(start), .slope(slope), .threshold(threshold),
    .memAddr(memAddr), .memBit(memBit), .busy(busy), .done(done),
    .trackCount(trackCount), .overflow(overflow), .fifoValid(fifoValid),
    .fifoOff(fifoOff), .fifoPts(fifoPts), .fifoPop(fifoPop)
  );

  logic img [NP][M];
  int checks = 0, errors = 0, cyc = 0;
  int qOff[$], qPts[$];

  always @(posedge clk) cyc <= cyc + 1;

  // memory model: returns the stored bit even for wrapped addresses
  always @(posedge clk)
    for (int p = 0; p < NP; p++) memBit[p] <= img[p][memAddr[p*AW +: AW]];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: pops and compares whenever allowed
  always @(negedge clk) begin
    fifoPop = 1'b0;
    if (popEn && fifoValid) begin
      if (qOff.size() == 0) begin
        check(0, "R6", "unexpected entry offset", int'(fifoOff), -1);
      end else begin
        int eo, ep;
        eo = qOff.pop_front();
        ep = qPts.pop_front();
        check(int'(fifoOff) == eo, "R6", "entry offset", int'(fifoOff), eo);
        check(int'(fifoPts) == ep, "R3 R6", "entry points", int'(fifoPts), ep);
      end
      fifoPop = 1'b1;
    end
  end

  task automatic clearImg();
    for (int p = 0; p < NP; p++)
      for (int c = 0; c < M; c++) img[p][c] = 1'b0;
  endtask

  task automatic addTrack(input int off, input int s, input int nPl);
    for (int p = 0; p < nPl; p++) begin
      int a;
      a = off + p * s;
      if (a >= 0 && a < M) img[p][a] = 1'b1;
    end
  endtask

  task automatic runScan(input int s, input int thr, input bit popsDuring,
                         input bit extraStart, input string tag);
    int cnt[M];
    int nPk, room, startCyc, guard, lat;
    bit expOvf;
    for (int o = 0; o < M; o++) begin
      cnt[o] = 0;
      for (int p = 0; p < NP; p++) begin
        int a;
        a = o + p * s;
        if (a >= 0 && a < M && img[p][a]) cnt[o]++;
      end
    end
    nPk = 0;
    room = DEPTH - qOff.size();
    for (int o = 0; o < M; o++) begin
      int prv, nxt;
      prv = (o == 0) ? 0 : cnt[o-1];
      nxt = (o == M - 1) ? 0 : cnt[o+1];
      if (cnt[o] >= thr && cnt[o] > prv && cnt[o] >= nxt) begin
        if (popsDuring || nPk < room) begin
          qOff.push_back(o);
          qPts.push_back(cnt[o]);
        end
        nPk++;
      end
    end
    expOvf = !popsDuring && (nPk > room);

    @(negedge clk);
    slope = (AW+1)'(s);
    threshold = CW'(thr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    startCyc = cyc;
    if (popsDuring) begin
      @(posedge clk);
      @(posedge clk);
      #1 popEn = 1'b1;
    end
    if (extraStart) begin
      repeat (10) @(negedge clk);
      check(busy == 1'b1, "R9", "busy mid-scan", int'(busy), 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!done && guard < 1000);
    lat = cyc - startCyc;
    check(lat == M + 2, extraStart ? "R9 R10" : "R9", {tag, " done latency"}, lat, M + 2);
    check(int'(trackCount) == nPk, "R7", {tag, " track count"}, int'(trackCount), nPk);
    check(overflow == expOvf, "R7 R8", {tag, " overflow"}, int'(overflow), int'(expOvf));
  endtask

  task automatic drain(input string tag);
    int guard;
    popEn = 1'b1;
    guard = 0;
    while ((qOff.size() != 0 || fifoValid) && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    popEn = 1'b0;
    check(fifoValid == 1'b0, "R6", {tag, " queue empty after drain"}, int'(fifoValid), 0);
    check(qOff.size() == 0, "R6", {tag, " all expected entries seen"}, qOff.size(), 0);
    check(done == 1'b1, "R9", {tag, " done held"}, int'(done), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; popEn = 1'b0; fifoPop = 1'b0;
    slope = '0; threshold = '0;
    clearImg();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !fifoValid && !overflow, "R1", "idle flags",
          int'({busy, done, fifoValid, overflow}), 0);
    check(trackCount == '0, "R1", "track count at reset", int'(trackCount), 0);

    // vertical tracks, one partial, one noise pixel; a start during the scan
    clearImg();
    addTrack(5, 0, 8); addTrack(20, 0, 6); addTrack(40, 0, 8);
    img[3][30] = 1'b1;
    runScan(0, 4, 1'b0, 1'b1, "R3 R10 vertical");
    drain("vertical");

    // positive slope with lines leaving the memory; wrap-around trap pixels
    clearImg();
    addTrack(3, 2, 8); addTrack(50, 2, 8);
    for (int p = 2; p < NP; p++) img[p][(60 + 2*p) % M] = 1'b1;
    runScan(2, 3, 1'b0, 1'b0, "R2 slope+2");
    drain("slope+2");

    // negative slope, partially outside
    clearImg();
    addTrack(10, -1, 8); addTrack(3, -1, 8);
    runScan(-1, 4, 1'b0, 1'b0, "R2 slope-1");
    drain("slope-1");

    // edges, a plateau and a sub-threshold bump
    clearImg();
    addTrack(0, 0, 8); addTrack(10, 0, 8); addTrack(11, 0, 8); addTrack(63, 0, 8);
    addTrack(30, 0, 3);
    runScan(0, 4, 1'b0, 1'b0, "R4 R5 plateau");
    drain("plateau");

    // more tracks than the queue holds
    clearImg();
    for (int o = 0; o < M; o += 3) addTrack(o, 1, 8);
    runScan(1, 2, 1'b0, 1'b0, "R7 overflow");

    // queue still full; first push meets the first pop
    clearImg();
    addTrack(0, 0, 8); addTrack(20, 0, 5);
    runScan(0, 4, 1'b1, 1'b0, "R8 push-pop");
    drain("push-pop");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule